// File: doc/BRIEF.md
# Line-Locked Horizontal Pulse Generator

This block makes one horizontal pulse per video line and keeps it in step with the separated sync of the incoming signal. The oscillator is digital. A phase accumulator, driven by a frequency word, gives a tick enable. A line counter divides those ticks by 440. At each rising sync edge the counter's phase error is measured and part or all of it is corrected. The size of the correction depends on the selected loop speed.

A coincidence detector watches how often the sync edge falls near the expected count and raises a lock flag. A calibration sequencer sets the frequency word so that one reference period holds 440 ticks. It waits until software reports that configuration is complete. It runs again every time lock is lost. While it runs, the output pulse is held low. Once calibrated, the output is either a copy of incoming sync or a clamp pulse at a fixed tick position in the line.

Top module: `line_pulse_gen`

## Requirements
- R1: The line counter advances on each accumulator overflow tick and wraps from 439 to 0. With no sync edges arriving, consecutive clamp pulses are 440 ticks apart.
- R2: After reset, `hpulse`, `cal_done` and `locked` are 0. Calibration does not start, and `cal_done` stays 0, until `cfg_done` has been seen high for a cycle.
- R3: Calibration counts ticks between consecutive `ref_strobe` pulses. If the count is below 439, the frequency word goes up by one. If it is above 441, the word goes down by one. A count of 439 to 441 sets `cal_done`. The word changes by at most one per step.
- R4: `hpulse` is 0 in every cycle that follows a cycle in which `cal_done` was 0.
- R5: When `locked` falls while calibrated, `cal_done` drops on the next cycle and calibration repeats from the current frequency word.
- R6: With `out_sel` = 1 and calibrated, `hpulse` equals `sync_in` delayed by one clock.
- R7: With `out_sel` = 0 and calibrated, `hpulse` is high while the line count is at least 40 and below 72. That is 32 ticks, starting 40 ticks after the wrap.
- R8: The phase error is the count at a rising sync edge, taken as count minus 440 when the count is 220 or more. The counter is moved back by the error shifted right: `loop_spd` 11 (fast) shifts by 0, 00 (normal) by 1, 01 (slow) by 2, and 10 uses shift 2 while locked and shift 0 while unlocked.
- R9: In normal mode (`loop_spd` 00) with `noisy` = 1, the slow shift of 2 is used.
- R10: A sync edge is good when its phase error lies within ±4 ticks. `locked` rises after 8 consecutive good edges, or after 16 when `low_sens` = 1.
- R11: `locked` falls only after 3 consecutive edges outside the window. One or two bad edges followed by a good one leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Separated sync level, high during the sync pulse |
| cfg_done | input | 1 | One-cycle strobe: all configuration written |
| ref_strobe | input | 1 | One-cycle strobe at each reference period |
| out_sel | input | 1 | 1: copy of sync, 0: clamp pulse |
| loop_spd | input | 2 | Loop speed code (R8) |
| noisy | input | 1 | Noise indication for automatic speed choice |
| low_sens | input | 1 | Makes coincidence harder to satisfy |
| hpulse | output | 1 | Horizontal output pulse |
| cal_done | output | 1 | Oscillator frequency calibrated |
| locked | output | 1 | Coincidence lock flag |

## Verification
The bench starts the oscillator off frequency and holds back the configuration strobe. A design that calibrated early, or let pulses out before calibration, shows pulses during that window. It then delays a single sync edge by 32 ticks under each loop-speed code and measures where the next clamp starts. A wrong gain mapping, or a noise or lock override that is ignored, moves that start by tens of clocks. Lock loss is forced with three late lines, and relock is counted edge by edge with and without reduced sensitivity. An off-by-one in the good-line or bad-line count, or a missing recalibration, shows up there. Copy mode is run with random sync widths, and free-running pulse spacing is checked to catch a wrong wrap value.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int ERR_W = 16;

    typedef enum logic [1:0] {
        SPD_NORMAL   = 2'b00,
        SPD_SLOW     = 2'b01,
        SPD_SLOWFAST = 2'b10,
        SPD_FAST     = 2'b11
    } loop_spd_e;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_ARM,
        CAL_MEAS,
        CAL_DONE
    } cal_state_e;

    typedef struct packed {
        logic                    strobe;
        logic signed [ERR_W-1:0] err;
    } phase_obs_t;

    function automatic logic [1:0] gain_shift(loop_spd_e spd, logic noisy, logic locked);
        logic [1:0] sh;
        case (spd)
            SPD_FAST:     sh = 2'd0;
            SPD_SLOW:     sh = 2'd2;
            SPD_SLOWFAST: sh = locked ? 2'd2 : 2'd0;
            default:      sh = noisy ? 2'd2 : 2'd1;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/hp_nco.sv
module hp_nco #(
    parameter int ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] fw,
    output logic             tick
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, fw};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= sum[ACC_W-1:0];
            tick <= sum[ACC_W];
        end
    end

    // R1: a tick can only follow an accumulator that was about to overflow
    assert_tick_source_R1: assert property (@(posedge clk) disable iff (rst)
        tick |-> ({1'b0, $past(acc)} + {1'b0, $past(fw)}) > {1'b0, {ACC_W{1'b1}}});
endmodule

// File: rtl/hp_line_pll.sv
module hp_line_pll
    import hp_pkg::*;
#(
    parameter int LINE_TICKS = 440,
    localparam int CNT_W = $clog2(LINE_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             edge_s,
    input  logic [1:0]       shift,
    output logic [CNT_W-1:0] cnt,
    output phase_obs_t       obs
);
    localparam int HALF = LINE_TICKS / 2;
    localparam logic signed [ERR_W-1:0] LT_S = ERR_W'(LINE_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_TICKS - 1);

    logic [CNT_W-1:0]        cnt_adv;
    logic signed [ERR_W-1:0] err, corr, tgt;

    always_comb begin
        cnt_adv = cnt;
        if (tick) cnt_adv = (cnt == LAST) ? '0 : cnt + 1'b1;
        err = $signed(ERR_W'(cnt));
        if (cnt >= CNT_W'(HALF)) err = err - LT_S;
        corr = err >>> shift;
        tgt  = $signed(ERR_W'(cnt_adv)) - corr;
        if (tgt < 0)          tgt = tgt + LT_S;
        else if (tgt >= LT_S) tgt = tgt - LT_S;
    end

    assign obs.strobe = edge_s;
    assign obs.err    = err;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (edge_s) cnt <= CNT_W'(tgt);
        else             cnt <= cnt_adv;
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !edge_s && cnt == LAST) |=> cnt == '0);
    assert_fast_align_R8: assert property (@(posedge clk) disable iff (rst)
        (edge_s && shift == 2'd0) |=> cnt <= CNT_W'(1));
endmodule

// File: rtl/hp_coinc.sv
module hp_coinc
    import hp_pkg::*;
#(
    parameter int WIN       = 4,
    parameter int LOCK_N    = 8,
    parameter int LOCK_N_LS = 16,
    parameter int LOSS_N    = 3,
    localparam int G_W = $clog2(LOCK_N_LS + 1),
    localparam int B_W = $clog2(LOSS_N + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  phase_obs_t obs,
    input  logic       low_sens,
    output logic       locked
);
    localparam logic signed [ERR_W-1:0] WIN_S = ERR_W'(WIN);

    logic [G_W-1:0] good;
    logic [B_W-1:0] bad;
    logic           in_win;
    int             need;

    assign in_win = (obs.err <= WIN_S) && (obs.err >= -WIN_S);
    assign need   = low_sens ? LOCK_N_LS : LOCK_N;

    always_ff @(posedge clk) begin
        if (rst) begin
            good   <= '0;
            bad    <= '0;
            locked <= 1'b0;
        end else if (obs.strobe) begin
            if (in_win) begin
                bad <= '0;
                if (int'(good) < LOCK_N_LS) good <= good + 1'b1;
                if (int'(good) + 1 >= need) locked <= 1'b1;
            end else begin
                good <= '0;
                if (int'(bad) < LOSS_N) bad <= bad + 1'b1;
                if (int'(bad) + 1 >= LOSS_N) locked <= 1'b0;
            end
        end
    end

    assert_lock_on_good_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(obs.strobe && in_win));
    assert_unlock_on_bad_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(obs.strobe && !in_win));
endmodule

// File: rtl/hp_calib.sv
module hp_calib
    import hp_pkg::*;
#(
    parameter int ACC_W      = 10,
    parameter int FW_INIT    = 500,
    parameter int LINE_TICKS = 440,
    parameter int CAL_TOL    = 1,
    parameter int WC_W       = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_done,
    input  logic             ref_strobe,
    input  logic             tick,
    input  logic             locked,
    output logic [ACC_W-1:0] fw,
    output logic             cal_done
);
    localparam logic [WC_W-1:0]  LO    = WC_W'(LINE_TICKS - CAL_TOL);
    localparam logic [WC_W-1:0]  HI    = WC_W'(LINE_TICKS + CAL_TOL);
    localparam logic [ACC_W-1:0] FW_HI = {ACC_W{1'b1}};

    cal_state_e      state;
    logic [WC_W-1:0] win_cnt;
    logic            locked_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CAL_IDLE;
            fw       <= ACC_W'(FW_INIT);
            win_cnt  <= '0;
            locked_d <= 1'b0;
            cal_done <= 1'b0;
        end else begin
            locked_d <= locked;
            if (tick && win_cnt != '1) win_cnt <= win_cnt + 1'b1;
            case (state)
                CAL_IDLE: if (cfg_done) state <= CAL_ARM;
                CAL_ARM: if (ref_strobe) begin
                    state   <= CAL_MEAS;
                    win_cnt <= WC_W'(tick);
                end
                CAL_MEAS: if (ref_strobe) begin
                    win_cnt <= WC_W'(tick);
                    if (win_cnt < LO) begin
                        if (fw != FW_HI) fw <= fw + 1'b1;
                    end else if (win_cnt > HI) begin
                        if (fw > ACC_W'(1)) fw <= fw - 1'b1;
                    end else begin
                        state    <= CAL_DONE;
                        cal_done <= 1'b1;
                    end
                end
                default: if (locked_d && !locked) begin
                    state    <= CAL_ARM;
                    cal_done <= 1'b0;
                end
            endcase
        end
    end

    assert_fw_step_R3: assert property (@(posedge clk) disable iff (rst)
        (fw != $past(fw)) |-> ($past(ref_strobe) &&
            ((fw == $past(fw) + 1'b1) || (fw == $past(fw) - 1'b1))));
    assert_done_on_ref_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> $past(ref_strobe));
    assert_wait_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        (state == CAL_IDLE && !cfg_done) |=> !cal_done);
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
    import hp_pkg::*;
#(
    parameter int ACC_W      = 10,
    parameter int FW_INIT    = 500,
    parameter int LINE_TICKS = 440,
    parameter int CAL_TOL    = 1,
    parameter int CLP_START  = 40,
    parameter int CLP_W      = 32,
    parameter int WIN        = 4,
    parameter int LOCK_N     = 8,
    parameter int LOCK_N_LS  = 16,
    parameter int LOSS_N     = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    input  logic       cfg_done,
    input  logic       ref_strobe,
    input  logic       out_sel,
    input  logic [1:0] loop_spd,
    input  logic       noisy,
    input  logic       low_sens,
    output logic       hpulse,
    output logic       cal_done,
    output logic       locked
);
    localparam int CNT_W = $clog2(LINE_TICKS);
    localparam int WC_W  = $clog2(4 * LINE_TICKS);
    localparam logic [CNT_W-1:0] CLP_LO = CNT_W'(CLP_START);
    localparam logic [CNT_W-1:0] CLP_HI = CNT_W'(CLP_START + CLP_W);

    logic [ACC_W-1:0] fw;
    logic             tick, s1, s2, edge_s, clamp_win;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       shift;
    phase_obs_t       obs;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            hpulse <= 1'b0;
        end else begin
            s1     <= sync_in;
            s2     <= s1;
            hpulse <= cal_done & (out_sel ? sync_in : clamp_win);
        end
    end

    assign edge_s    = s1 & ~s2;
    assign shift     = gain_shift(loop_spd_e'(loop_spd), noisy, locked);
    assign clamp_win = (cnt >= CLP_LO) && (cnt < CLP_HI);

    hp_nco #(.ACC_W(ACC_W)) u_nco (
        .clk(clk), .rst(rst), .fw(fw), .tick(tick)
    );

    hp_line_pll #(.LINE_TICKS(LINE_TICKS)) u_pll (
        .clk(clk), .rst(rst), .tick(tick), .edge_s(edge_s),
        .shift(shift), .cnt(cnt), .obs(obs)
    );

    hp_coinc #(.WIN(WIN), .LOCK_N(LOCK_N), .LOCK_N_LS(LOCK_N_LS), .LOSS_N(LOSS_N)) u_coinc (
        .clk(clk), .rst(rst), .obs(obs), .low_sens(low_sens), .locked(locked)
    );

    hp_calib #(.ACC_W(ACC_W), .FW_INIT(FW_INIT), .LINE_TICKS(LINE_TICKS),
               .CAL_TOL(CAL_TOL), .WC_W(WC_W)) u_cal (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .ref_strobe(ref_strobe),
        .tick(tick), .locked(locked), .fw(fw), .cal_done(cal_done)
    );

    assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !cal_done |=> !hpulse);
    assert_recal_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && cal_done) |=> !cal_done);
    assert_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (cal_done && out_sel) |=> (hpulse == $past(sync_in)));
    assert_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !out_sel && cnt == CLP_LO) |=> hpulse);
endmodule

// File: tb/line_pulse_gen_test.sv
module line_pulse_gen_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0, cfg_done = 1'b0, ref_strobe = 1'b0, out_sel = 1'b0;
    logic [1:0] loop_spd = 2'b11;
    logic noisy = 1'b0, low_sens = 1'b0;
    logic hpulse, cal_done, locked;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    int sync_edges = 0, rise_cyc = 0, period = 880, extra = 0, late_lines = 0;
    bit run_sync = 0, rand_w = 0, chk_copy = 0;
    int hp_rises = 0, hp_falls = 0, hp_rise_cyc = 0, hp_width = 0;
    logic hp_prev = 1'b0, p_sync = 1'b0, p_cal = 1'b0, p_sel = 1'b0;

    line_pulse_gen uut (
        .clk(clk), .rst(rst), .sync_in(sync_in), .cfg_done(cfg_done),
        .ref_strobe(ref_strobe), .out_sel(out_sel), .loop_spd(loop_spd),
        .noisy(noisy), .low_sens(low_sens), .hpulse(hpulse),
        .cal_done(cal_done), .locked(locked)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc    <= cyc + 1;
        p_sync <= sync_in;
        p_cal  <= cal_done;
        p_sel  <= out_sel;
    end

    task automatic check(string req, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // continuous checks at the falling edge: R4 gating and R6 copy
    always @(negedge clk) begin
        if (!rst) begin
            if (!p_cal) check("R4 hpulse gated", int'(hpulse), 0, 0);
            if (chk_copy && p_cal && p_sel) check("R6 copy", int'(hpulse), int'(p_sync), int'(p_sync));
        end
        if (hpulse && !hp_prev) begin hp_rises++; hp_rise_cyc = cyc; end
        if (!hpulse && hp_prev) begin hp_falls++; hp_width = cyc - hp_rise_cyc; end
        hp_prev = hpulse;
    end

    initial begin : ref_gen
        wait (!rst);
        forever begin
            repeat (879) @(posedge clk);
            #1 ref_strobe = 1'b1;
            @(posedge clk);
            #1 ref_strobe = 1'b0;
        end
    end

    initial begin : sync_gen
        wait (run_sync);
        forever begin
            int gap, w;
            @(posedge clk);
            #1 sync_in = 1'b1;
            rise_cyc = cyc;
            sync_edges++;
            gap = period + extra + ((late_lines > 0) ? 200 : 0);
            extra = 0;
            if (late_lines > 0) late_lines--;
            w = rand_w ? int'($urandom_range(10, 100)) : 30;
            repeat (w) @(posedge clk);
            #1 sync_in = 1'b0;
            repeat (gap - w - 1) @(posedge clk);
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_edges(int n);
        int target = sync_edges + n;
        while (sync_edges < target) @(negedge clk);
    endtask

    task automatic wait_hp_rise(output int ok);
        int start = hp_rises;
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (hp_rises != start) begin ok = 1; break; end
        end
    endtask

    task automatic wait_hp_fall();
        int start = hp_falls;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (hp_falls != start) break;
        end
    endtask

    // one sync edge arrives 64 clocks (32 ticks) late; clamp start after it
    function automatic int exp_delay(int shift_v);
        int e = 32;
        int c = e - (e >>> shift_v);
        return 2 * (40 - c) + 3;
    endfunction

    task automatic speed_case(string req, logic [1:0] spd, logic nz, int shift_v);
        int ok;
        loop_spd = spd;
        noisy = nz;
        wait_edges(1);
        wait_cycles(50);
        extra = 64;
        wait_edges(2);
        wait_hp_rise(ok);
        check(req, hp_rise_cyc - rise_cyc, exp_delay(shift_v) - 6, exp_delay(shift_v) + 6);
        loop_spd = 2'b11;
        noisy = 1'b0;
        wait_edges(3);
        wait_cycles(10);
        check("R11 lock kept after late edges", int'(locked), 1, 1);
    endtask

    task automatic lock_loss(bit ls, int need);
        low_sens = ls;
        wait_edges(1);
        wait_cycles(50);
        late_lines = 3;
        wait_edges(3);
        wait_cycles(10);
        check("R11 two bad edges keep lock", int'(locked), 1, 1);
        wait_edges(1);
        wait_cycles(10);
        check("R11 third bad edge drops lock", int'(locked), 0, 0);
        check("R5 recalibration starts", int'(cal_done), 0, 0);
        wait_edges(need - 1);
        wait_cycles(10);
        check("R10 one good edge short", int'(locked), 0, 0);
        wait_edges(1);
        wait_cycles(10);
        check("R10 lock after required good edges", int'(locked), 1, 1);
        for (int i = 0; i < 8 * 880 && !cal_done; i++) @(negedge clk);
        check("R5 recalibration completes", int'(cal_done), 1, 1);
        low_sens = 1'b0;
    endtask

    initial begin : main
        int ok, r2, r3;
        void'($urandom(32'd7021));
        repeat (10) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R2 reset hpulse", int'(hpulse), 0, 0);
        check("R2 reset cal_done", int'(cal_done), 0, 0);
        check("R2 reset locked", int'(locked), 0, 0);

        run_sync = 1;
        wait_edges(6);
        check("R2 no calibration without cfg_done", int'(cal_done), 0, 0);
        check("R2 no pulses without cfg_done", hp_rises, 0, 0);

        @(posedge clk); #1 cfg_done = 1'b1;
        @(posedge clk); #1 cfg_done = 1'b0;
        for (int i = 0; i < 25 * 880 && !cal_done; i++) @(negedge clk);
        check("R3 calibration completes", int'(cal_done), 1, 1);

        wait_edges(10);
        wait_cycles(10);
        check("R10 locked on clean sync", int'(locked), 1, 1);

        for (int k = 0; k < 3; k++) begin
            wait_edges(1);
            wait_hp_rise(ok);
            check("R7 clamp start after sync", hp_rise_cyc - rise_cyc, 77, 89);
            wait_hp_fall();
            check("R7 R3 clamp width", hp_width, 61, 67);
        end

        // free-running spacing with one long line
        wait_edges(1);
        wait_cycles(50);
        period = 3000;
        wait_edges(1);
        wait_cycles(2);
        period = 880;
        wait_hp_rise(ok);
        wait_hp_rise(ok);
        r2 = hp_rise_cyc;
        wait_hp_rise(ok);
        r3 = hp_rise_cyc;
        check("R1 free-run line period", r3 - r2, 876, 888);
        wait_edges(4);

        speed_case("R8 fast shift 0", 2'b11, 1'b0, 0);
        speed_case("R8 normal shift 1", 2'b00, 1'b0, 1);
        speed_case("R8 slow shift 2", 2'b01, 1'b0, 2);
        speed_case("R9 noisy normal uses slow", 2'b00, 1'b1, 2);
        speed_case("R8 slow/fast while locked", 2'b10, 1'b0, 2);

        out_sel = 1'b1;
        rand_w = 1;
        chk_copy = 1;
        wait_edges(6);
        chk_copy = 0;
        rand_w = 0;
        out_sel = 1'b0;
        wait_edges(2);

        lock_loss(1'b0, 8);
        wait_edges(2);
        lock_loss(1'b1, 16);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule